// File: doc/BRIEF.md
# Halfword-Swapping DMA Memory Port

This block is the memory-facing front end of a network-controller DMA channel. A requester hands it one transfer at a time: a byte offset, a byte length, a direction and a raw-mode flag. The block ORs the offset with a 32-bit base register to form the bus address. It then walks the transfer as a run of halfword beats on a valid/ready memory interface. Write data is pulled from the requester one halfword per accepted beat. Read data is handed back one halfword per accepted beat.

With the raw flag set, bytes move untouched at the address and length given. An odd final byte is marked by a partial byte-enable. With the raw flag clear, the block clears the low bit of both address and length, and it exchanges the two bytes of each halfword in both directions. In this mode, writes are also cut into bursts of at most 64 bytes. Each burst opens with a head marker on the memory side, and the address runs on without a gap. The base register can be loaded through a small register port while no transfer is in flight.

Top module: `hswap_dma_port`

## Requirements
- R1: The first beat's address is the request offset bitwise-ORed with the base register, never the sum. A base write on the same clock edge that accepts a request applies only to later requests.
- R2: With `req_raw`=1, the address and length are used as given and data is not swapped. Beats cover `len` bytes. A final beat with one byte left has `mem_be`=2'b01; every other beat has 2'b11. Bit 0 of `mem_be` is the byte at `mem_addr`, carried in `mem_wdata[7:0]`/`mem_rdata[7:0]`.
- R3: With `req_raw`=0, address bit 0 and length bit 0 are cleared before the transfer, so every beat is even-addressed with `mem_be`=2'b11.
- R4: With `req_raw`=0, `mem_wdata` is `{wr_data[7:0], wr_data[15:8]}` and `rd_data` is `{mem_rdata[7:0], mem_rdata[15:8]}`.
- R5: `mem_head` is high on the first beat of every transfer. For swapped writes it is also high on every 32nd beat after that, which marks 64-byte bursts. For reads and raw writes it is high on the first beat only.
- R6: A request whose length is zero after trimming makes no memory beat. `done` is high in the cycle after acceptance.
- R7: A beat completes only when `mem_valid` and `mem_ready` are both high. While it is stalled, `mem_addr` holds its value. Each completed beat advances the address by 2.
- R8: `req_ready` is low from acceptance until `done`. Requests offered while it is low are ignored. `done` is a single-cycle pulse in the cycle after the last beat completes.
- R9: `cfg_we` loads `cfg_wdata` into the base register only when `req_ready` is high. `cfg_rdata` always shows the register.
- R10: After reset the base register is 0, `req_ready`=1, `mem_valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Base register write strobe |
| cfg_wdata | input | 32 | Base register write value |
| cfg_rdata | output | 32 | Base register contents |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = write to memory, 0 = read |
| req_raw | input | 1 | 1 = raw bytes, 0 = aligned halfword swap |
| req_offset | input | 32 | Byte offset ORed with the base |
| req_len | input | 12 | Byte length |
| wr_data | input | 16 | Write halfword for the current beat |
| wr_take | output | 1 | Current write halfword consumed |
| rd_data | output | 16 | Read halfword for the requester |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| done | output | 1 | Transfer finished pulse |
| mem_valid | output | 1 | Memory beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | Beat direction |
| mem_addr | output | 32 | Beat byte address |
| mem_be | output | 2 | Byte enables of the beat |
| mem_head | output | 1 | First beat of a burst |
| mem_wdata | output | 16 | Write data to memory |
| mem_rdata | input | 16 | Read data from memory, same cycle |

## Verification
Two things can land on the same clock edge: a base register write and the acceptance of a request. The bench raises `cfg_we` and `req_valid` in the same cycle while the block is idle. It then checks that the first beat's address uses the old base and that `cfg_rdata` afterwards shows the new base. The swapped long write sets a burst head on the same edge as an ordinary beat advance. The bench counts heads across a 65-beat transfer and checks them against the three expected from 64-byte bursts.

// File: rtl/hsdp_pkg.sv
package hsdp_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_FIN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/hsdp_addr_gen.sv
module hsdp_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              raw_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              empty_o
);
  // Address merge: OR, never add; swap mode drops bit 0.
  function automatic logic [ADDR_W-1:0] merge_addr(
    input logic [ADDR_W-1:0] off, input logic [ADDR_W-1:0] base, input logic raw);
    logic [ADDR_W-1:0] a;
    a = off | base;
    if (!raw) a[0] = 1'b0;
    return a;
  endfunction

  function automatic logic [LEN_W-1:0] trim_len(input logic [LEN_W-1:0] l, input logic raw);
    logic [LEN_W-1:0] t;
    t = l;
    if (!raw) t[0] = 1'b0;
    return t;
  endfunction

  assign addr_o  = merge_addr(offset_i, base_i, raw_i);
  assign len_o   = trim_len(len_i, raw_i);
  assign empty_o = (len_o == '0);
endmodule

// File: rtl/hsdp_lane_swap.sv
module hsdp_lane_swap #(
  parameter int DATA_W = 16
) (
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] d_o
);
  localparam int HALVES = DATA_W / 16;

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    assign d_o[g*16 +: 16] = en_i ? {d_i[g*16 +: 8], d_i[g*16+8 +: 8]} : d_i[g*16 +: 16];
  end
endmodule

// File: rtl/hsdp_beat_seq.sv
module hsdp_beat_seq
  import hsdp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 12,
  parameter int BEAT_BYTES  = 2,
  parameter int CHUNK_BEATS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [ADDR_W-1:0]     start_addr_i,
  input  logic [LEN_W-1:0]      start_len_i,
  input  logic                  start_empty_i,
  input  logic                  chunked_i,
  input  logic                  mem_ready_i,
  output logic                  busy_o,
  output logic                  run_o,
  output logic                  beat_fire_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [BEAT_BYTES-1:0] be_o,
  output logic                  head_o,
  output logic                  done_o
);
  localparam int CIDX_W = (CHUNK_BEATS > 1) ? $clog2(CHUNK_BEATS) : 1;
  localparam logic [CIDX_W-1:0] CIDX_LAST = CIDX_W'(CHUNK_BEATS - 1);
  localparam logic [LEN_W-1:0]  STEP_LEN  = LEN_W'(BEAT_BYTES);

  seq_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [CIDX_W-1:0] cidx_q;
  logic              head_q;
  logic              chunked_q;
  logic              last_beat;
  logic              chunk_wrap;
  logic [LEN_W-1:0]  step_len;

  assign run_o       = (state_q == SEQ_RUN);
  assign busy_o      = (state_q != SEQ_IDLE);
  assign done_o      = (state_q == SEQ_FIN);
  assign beat_fire_o = run_o && mem_ready_i;
  assign last_beat   = (rem_q <= STEP_LEN);
  assign step_len    = last_beat ? rem_q : STEP_LEN;
  assign chunk_wrap  = (cidx_q == CIDX_LAST);
  assign addr_o      = addr_q;
  assign head_o      = run_o && head_q;

  for (genvar b = 0; b < BEAT_BYTES; b++) begin : g_be
    assign be_o[b] = (rem_q > LEN_W'(b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      addr_q    <= '0;
      rem_q     <= '0;
      cidx_q    <= '0;
      head_q    <= 1'b0;
      chunked_q <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            addr_q    <= start_addr_i;
            rem_q     <= start_len_i;
            cidx_q    <= '0;
            head_q    <= 1'b1;
            chunked_q <= chunked_i;
            state_q   <= start_empty_i ? SEQ_FIN : SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (beat_fire_o) begin
            addr_q <= addr_q + ADDR_W'(BEAT_BYTES);
            rem_q  <= rem_q - step_len;
            cidx_q <= chunk_wrap ? '0 : cidx_q + 1'b1;
            head_q <= chunked_q && chunk_wrap;
            if (last_beat) state_q <= SEQ_FIN;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hswap_dma_port.sv
module hswap_dma_port #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 12,
  parameter int DATA_W      = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_wdata,
  output logic [ADDR_W-1:0]     cfg_rdata,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_raw,
  input  logic [ADDR_W-1:0]     req_offset,
  input  logic [LEN_W-1:0]      req_len,
  input  logic [DATA_W-1:0]     wr_data,
  output logic                  wr_take,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic                  done,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic                  mem_write,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W/8-1:0]   mem_be,
  output logic                  mem_head,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata
);
  localparam int BEAT_BYTES  = DATA_W / 8;
  localparam int CHUNK_BEATS = CHUNK_BYTES / BEAT_BYTES;

  logic [ADDR_W-1:0] base_q;
  logic              write_q;
  logic              raw_q;
  logic              busy;
  logic              req_fire;
  logic              beat_fire;
  logic [ADDR_W-1:0] trim_addr;
  logic [LEN_W-1:0]  trim_len;
  logic              trim_empty;

  assign req_ready = !busy;
  assign req_fire  = req_valid && req_ready;
  assign cfg_rdata = base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      write_q <= 1'b0;
      raw_q   <= 1'b1;
    end else begin
      if (cfg_we && !busy) base_q <= cfg_wdata;
      if (req_fire) begin
        write_q <= req_write;
        raw_q   <= req_raw;
      end
    end
  end

  hsdp_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
    .offset_i (req_offset),
    .base_i   (base_q),
    .len_i    (req_len),
    .raw_i    (req_raw),
    .addr_o   (trim_addr),
    .len_o    (trim_len),
    .empty_o  (trim_empty)
  );

  hsdp_beat_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES), .CHUNK_BEATS(CHUNK_BEATS)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (req_fire),
    .start_addr_i  (trim_addr),
    .start_len_i   (trim_len),
    .start_empty_i (trim_empty),
    .chunked_i     (req_write && !req_raw),
    .mem_ready_i   (mem_ready),
    .busy_o        (busy),
    .run_o         (mem_valid),
    .beat_fire_o   (beat_fire),
    .addr_o        (mem_addr),
    .be_o          (mem_be),
    .head_o        (mem_head),
    .done_o        (done)
  );

  hsdp_lane_swap #(.DATA_W(DATA_W)) u_swap_wr (
    .en_i (!raw_q),
    .d_i  (wr_data),
    .d_o  (mem_wdata)
  );

  hsdp_lane_swap #(.DATA_W(DATA_W)) u_swap_rd (
    .en_i (!raw_q),
    .d_i  (mem_rdata),
    .d_o  (rd_data)
  );

  assign mem_write = write_q;
  assign wr_take   = beat_fire && write_q;
  assign rd_valid  = beat_fire && !write_q;
endmodule

// File: rtl/hsdp_checker.sv
module hsdp_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_fire,
  input logic                trim_empty,
  input logic [ADDR_W-1:0]   req_offset,
  input logic [ADDR_W-1:0]   base_q,
  input logic                raw_q,
  input logic                req_ready,
  input logic                done,
  input logic                mem_valid,
  input logic                mem_ready,
  input logic                mem_write,
  input logic                mem_head,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_be,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic [DATA_W-1:0]   wr_data,
  input logic [ADDR_W-1:0]   cfg_rdata
);
  // R1: upper address bits come from OR of offset and base at acceptance
  p_or_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !trim_empty |=> mem_addr[ADDR_W-1:1] ==
      ($past(req_offset[ADDR_W-1:1]) | $past(base_q[ADDR_W-1:1])));

  // R2: raw mode passes write data untouched
  p_raw_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && raw_q |-> mem_wdata == wr_data);

  // R3: swap mode beats are even and full
  p_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !raw_q |-> !mem_addr[0] && (&mem_be));

  // R4: swap mode exchanges the bytes of the low halfword
  p_swap_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && !raw_q |-> mem_wdata[15:0] == {wr_data[7:0], wr_data[15:8]});

  // R5: every transfer opens with a head beat
  p_first_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !trim_empty |=> mem_head);

  // R6: empty request finishes with no beat
  p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && trim_empty |=> done && !mem_valid);

  // R7: a stalled beat holds its address
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

  // R8: busy while beats are outstanding; done is one cycle then idle
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  // R9: base register frozen while busy
  p_base_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(cfg_rdata));
endmodule

bind hswap_dma_port hsdp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hsdp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_fire   (req_fire),
  .trim_empty (trim_empty),
  .req_offset (req_offset),
  .base_q     (base_q),
  .raw_q      (raw_q),
  .req_ready  (req_ready),
  .done       (done),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_write  (mem_write),
  .mem_head   (mem_head),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_wdata  (mem_wdata),
  .wr_data    (wr_data),
  .cfg_rdata  (cfg_rdata)
);

// File: tb/hswap_dma_port_tb.sv
module hswap_dma_port_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] offset;
    logic [31:0] base;
    logic [11:0] len;
    logic        raw;
    logic        wr;
    logic [31:0] exp_addr;
    logic [7:0]  exp_beats;
    logic [1:0]  exp_lastbe;
    logic [7:0]  exp_heads;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{32'h0000_0100, 32'h8000_0000, 12'd8,   1'b0, 1'b1, 32'h8000_0100, 8'd4,  2'b11, 8'd1},
    '{32'h0000_0103, 32'h0000_0010, 12'd7,   1'b0, 1'b0, 32'h0000_0112, 8'd3,  2'b11, 8'd1},
    '{32'h0000_0103, 32'h0000_0010, 12'd7,   1'b1, 1'b1, 32'h0000_0113, 8'd4,  2'b01, 8'd1},
    '{32'h0000_0040, 32'h0000_0000, 12'd1,   1'b0, 1'b1, 32'h0000_0040, 8'd0,  2'b00, 8'd0},
    '{32'h0000_0200, 32'h0000_1000, 12'd130, 1'b0, 1'b1, 32'h0000_1200, 8'd65, 2'b11, 8'd3},
    '{32'h0000_0200, 32'h0000_1000, 12'd130, 1'b0, 1'b0, 32'h0000_1200, 8'd65, 2'b11, 8'd1},
    '{32'h0000_0200, 32'h0000_1000, 12'd130, 1'b1, 1'b1, 32'h0000_1200, 8'd65, 2'b11, 8'd1},
    '{32'h0000_00F0, 32'h0000_00FF, 12'd5,   1'b1, 1'b0, 32'h0000_00FF, 8'd3,  2'b01, 8'd1},
    '{32'h0000_00F0, 32'h0000_00FF, 12'd5,   1'b0, 1'b0, 32'h0000_00FE, 8'd2,  2'b11, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_raw = 1'b0;
  logic [31:0] req_offset = '0;
  logic [11:0] req_len = '0;
  logic [15:0] wr_data = '0;
  logic        wr_take;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        done;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic        mem_write;
  logic [31:0] mem_addr;
  logic [1:0]  mem_be;
  logic        mem_head;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model: read data derived from the beat address.
  assign mem_rdata = {mem_addr[7:0] ^ 8'hA5, mem_addr[7:0]};

  hswap_dma_port dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_raw(req_raw), .req_offset(req_offset), .req_len(req_len),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_head(mem_head),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic [31:0] off, input logic [11:0] len,
                       input logic raw, input logic wr);
    req_offset = off; req_len = len; req_raw = raw; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 300; k++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  // Walk one vector with mem_ready held high; beat and data checks per beat.
  task automatic run_vec(input vec_t v, input int idx);
    int          beats = 0;
    int          heads = 0;
    logic [1:0]  last_be = 2'b00;
    logic        seen_done = 1'b0;
    logic [31:0] exp_a;
    logic [15:0] exp_d;
    logic [15:0] w;
    set_base(v.base);
    issue(v.offset, v.len, v.raw, v.wr);
    exp_a = v.exp_addr;
    for (int k = 0; k < 300; k++) begin
      if (done) begin seen_done = 1'b1; break; end
      if (mem_valid) begin
        w = 16'hC000 + 16'(beats);
        wr_data = w;
        #1;
        if (v.wr) begin
          exp_d = v.raw ? w : {w[7:0], w[15:8]};
          check(mem_addr == exp_a && mem_wdata == exp_d && wr_take,
                $sformatf("R1/R4 vec%0d beat%0d addr/wdata", idx, beats),
                {mem_addr, mem_wdata, 16'(wr_take)}, {exp_a, exp_d, 16'd1});
        end else begin
          exp_d = v.raw ? {mem_addr[7:0] ^ 8'hA5, mem_addr[7:0]}
                        : {mem_addr[7:0], mem_addr[7:0] ^ 8'hA5};
          check(mem_addr == exp_a && rd_data == exp_d && rd_valid,
                $sformatf("R1/R4 vec%0d beat%0d addr/rdata", idx, beats),
                {mem_addr, rd_data, 16'(rd_valid)}, {exp_a, exp_d, 16'd1});
        end
        if (mem_head) heads++;
        last_be = mem_be;
        beats++;
        exp_a = exp_a + 32'd2;
      end
      @(negedge clk);
    end
    check(beats == int'(v.exp_beats), $sformatf("R3 vec%0d beat count", idx),
          64'(beats), 64'(v.exp_beats));
    check(heads == int'(v.exp_heads), $sformatf("R5 vec%0d head count", idx),
          64'(heads), 64'(v.exp_heads));
    check(last_be == v.exp_lastbe, $sformatf("R2 vec%0d last byte enable", idx),
          64'(last_be), 64'(v.exp_lastbe));
    check(seen_done, $sformatf("R8 vec%0d done pulse", idx), 64'(seen_done), 64'd1);
    if (v.exp_beats == 8'd0)
      check(seen_done, $sformatf("R6 vec%0d empty finishes", idx), 64'(seen_done), 64'd1);
    @(negedge clk);
    check(req_ready && !done, $sformatf("R8 vec%0d idle after done", idx),
          {62'd0, req_ready, done}, 64'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary_and_end();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(req_ready && !mem_valid && !done && cfg_rdata == 32'd0, "R10 reset state",
          {cfg_rdata, 29'd0, req_ready, mem_valid, done}, {32'd0, 32'd4});
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 9; i++) run_vec(VECS[i], i);

    // R7/R8/R9: stall, refused request and frozen base while busy
    set_base(32'h0000_0000);
    mem_ready = 1'b0;
    issue(32'h0000_0010, 12'd6, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) begin
      check(mem_valid && mem_addr == 32'h10 && !wr_take, "R7 stalled beat holds",
            {31'd0, mem_valid, mem_addr}, {31'd0, 1'b1, 32'h10});
      cfg_we = 1'b1; cfg_wdata = 32'hDEAD_0000;
      req_valid = 1'b1; req_offset = 32'h0000_0800; req_len = 12'd2; req_raw = 1'b1;
      #1;
      check(!req_ready, "R8 request refused while busy", 64'(req_ready), 64'd0);
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
    end
    mem_ready = 1'b1;
    @(negedge clk);
    check(mem_addr == 32'h12, "R7 address steps by 2 after stall", 64'(mem_addr), 64'h12);
    wait_done();
    @(negedge clk);
    check(cfg_rdata == 32'd0, "R9 base write ignored while busy", 64'(cfg_rdata), 64'd0);
    @(negedge clk);
    check(!mem_valid, "R8 refused request left no transfer", 64'(mem_valid), 64'd0);

    // R1/R9: base write and request acceptance on the same edge
    set_base(32'h0000_0100);
    cfg_we = 1'b1; cfg_wdata = 32'h0000_2000;
    issue(32'h0000_0004, 12'd2, 1'b1, 1'b0);
    cfg_we = 1'b0;
    check(mem_valid && mem_addr == 32'h104, "R1 same-edge request uses old base",
          64'(mem_addr), 64'h104);
    check(cfg_rdata == 32'h2000, "R9 same-edge base write stored", 64'(cfg_rdata), 64'h2000);
    wait_done();
    @(negedge clk);

    summary_and_end();
  end
endmodule